// File: doc/BRIEF.md
# Four-Error Sector Correction Sequencer

This block drives the correction of one 512-byte NAND sector that is protected by a code able to fix up to four bit-errors. It is given the 10 parity bytes taken from the spare area. If every parity byte is 0xFF, it treats the sector as erased and stops there. Otherwise it splits the parity into eight 10-bit words and feeds them, one per cycle, into an external syndrome/locator engine. It then checks the four syndrome words. If they are non-zero, it asks the engine to locate the errors and polls the engine status until that work completes.

Once the engine reports the correction state, the sequencer fetches up to four raw error addresses with their XOR masks. It converts each raw address to a byte offset and patches the sector buffer through a byte-wide read/modify/write port. A correction that lands outside the data bytes is discarded. At the end it emits a one-cycle done pulse together with an uncorrectable flag and the error count.

The block handles only one sector at a time. The polynomial arithmetic stays inside the engine, and the sequencer only orders the accesses to it.

Top module: `ecc4_fix_seq`

## Requirements
- R1: If all 10 parity bytes equal 0xFF, the run ends with `done` pulsing, `err_count` = 0, `uncorrectable` = 0, no `eng_load`, no `eng_calc_start` and no buffer write.
- R2: Parity byte j occupies `parity[8j+7:8j]`. Word i is `parity[10i+9:10i]` for i = 0..7.
- R3: The eight words are presented on `eng_load_val` with `eng_load` high on eight consecutive cycles, in the order word 7, 6, ..., 0.
- R4: `eng_synd` (four 10-bit words) is sampled once, two cycles after the last load cycle, leaving one idle cycle between them. If it is all zero, the run ends with `err_count` = 0 and no `eng_calc_start`.
- R5: If the syndrome is non-zero, `eng_calc_start` pulses for exactly one cycle. The block then polls `eng_stat` each cycle until bits 11:10 are both zero.
- R6: The correction state sits in `eng_stat[9:8]`. Code 0 ends the run with count 0. Code 1 ends it with `uncorrectable` = 1, count 0 and the buffer untouched.
- R7: For codes 2 and 3, `err_count` = `eng_stat[17:16]` + 1, a value from 1 to 4.
- R8: The raw address of error 0 is `eng_addr_a[9:0]`, error 1 is `eng_addr_a[25:16]`, error 2 is `eng_addr_b[9:0]` and error 3 is `eng_addr_b[25:16]`. The XOR masks sit at bits 7:0 and 23:16 of `eng_val_a` and `eng_val_b` in the same way.
- R9: For each reported error, the offset is 519 − raw. The data byte at that offset is XORed with the mask only when the offset lies in 0..511; otherwise the error is dropped. Errors are applied in order 0 upward, so repeated offsets accumulate.
- R10: If bits 11:10 stay set for `POLL_LIMIT` consecutive polls, the run ends with `uncorrectable` = 1, count 0 and the buffer untouched.
- R11: `start` has no effect while `busy` is high.
- R12: `done` is high for one cycle per run. `uncorrectable` and `err_count` are valid while `done` is high and hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sector when idle |
| parity | input | 80 | Spare-area parity, byte j at bits 8j+7:8j |
| busy | output | 1 | A sector is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| uncorrectable | output | 1 | Run ended without a valid correction |
| err_count | output | 3 | Number of errors reported by the engine |
| eng_load | output | 1 | Parity word valid for the engine |
| eng_load_val | output | 10 | Parity word being loaded |
| eng_synd | input | 40 | Four syndrome words from the engine |
| eng_calc_start | output | 1 | Request error-location calculation |
| eng_stat | input | 18 | Engine status: [17:16] count−1, [11:10] busy, [9:8] state |
| eng_addr_a | input | 32 | Raw addresses of errors 0 and 1 |
| eng_addr_b | input | 32 | Raw addresses of errors 2 and 3 |
| eng_val_a | input | 32 | XOR masks of errors 0 and 1 |
| eng_val_b | input | 32 | XOR masks of errors 2 and 3 |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd | output | 1 | Buffer read strobe, data on the next cycle |
| buf_rdata | input | 8 | Buffer read data |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Corrected byte |

## Verification
The bench runs the block on random parity, with some syndromes non-zero and some zero. The engine model returns random state codes, counts, addresses and masks. A reference sector in the bench shows whether each correction hit the right byte with the right mask.

Directed cases separate the distinct paths:
- All-0xFF parity tests erased-sector detection.
- A zero syndrome is sampled only after the required idle cycle, so skipping that cycle is caught.
- State codes 0 and 1 are each exercised.
- A status that never clears tests the poll limit.
- Raw addresses 7, 8, 519 and 520 sit on the edges of the offset window.
- A repeated address tests accumulation.
- A start pulse issued mid-run tests that `start` is ignored while busy.

// File: rtl/ecc4_pkg.sv
package ecc4_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_LOAD, S_GAP, S_SYN, S_CALC, S_POLL, S_PICK, S_RD, S_WR, S_FIN
  } seq_st_t;
  localparam int RAW_W  = 10;
  localparam int MASK_W = 8;
  localparam int NERR   = 4;
endpackage

// File: rtl/ecc4_parity_unpack.sv
module ecc4_parity_unpack #(
  parameter int NB = 10,
  parameter int NW = 8,
  parameter int WW = 10
) (
  input  logic [NB*8-1:0]        par,
  output logic                   erased,
  output logic [NW-1:0][WW-1:0]  words
);
  assign erased = &par;
  for (genvar i = 0; i < NW; i++) begin : g_word
    assign words[i] = par[i*WW +: WW];
  end
endmodule

// File: rtl/ecc4_err_pick.sv
module ecc4_err_pick
  import ecc4_pkg::*;
#(
  parameter int SECT = 512,
  parameter int BIAS = 519,
  parameter int AW   = 9
) (
  input  logic [NERR-1:0][RAW_W-1:0]  raw,
  input  logic [NERR-1:0][MASK_W-1:0] msk,
  input  logic [1:0]                  sel,
  output logic [AW-1:0]               offset,
  output logic [MASK_W-1:0]           xorv,
  output logic                        hit
);
  localparam int DW = RAW_W + 2;
  logic [DW-1:0] diff;
  assign diff   = DW'(BIAS) - {2'b00, raw[sel]};
  assign hit    = !diff[DW-1] && (diff < DW'(SECT));
  assign offset = diff[AW-1:0];
  assign xorv   = msk[sel];
endmodule

// File: rtl/ecc4_poll_timer.sv
module ecc4_poll_timer #(
  parameter int LIMIT = 10240
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end
  assign expired = tick && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq
  import ecc4_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int PAR_BYTES  = 10,
  parameter int NWORDS     = 8,
  parameter int WORD_W     = 10,
  parameter int POLL_LIMIT = 10240,
  localparam int ADDR_W    = $clog2(SECT_BYTES),
  localparam int IDX_W     = $clog2(NWORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [PAR_BYTES*8-1:0]  parity,
  output logic                    busy,
  output logic                    done,
  output logic                    uncorrectable,
  output logic [2:0]              err_count,
  output logic                    eng_load,
  output logic [WORD_W-1:0]       eng_load_val,
  input  logic [4*WORD_W-1:0]     eng_synd,
  output logic                    eng_calc_start,
  input  logic [17:0]             eng_stat,
  input  logic [31:0]             eng_addr_a,
  input  logic [31:0]             eng_addr_b,
  input  logic [31:0]             eng_val_a,
  input  logic [31:0]             eng_val_b,
  output logic [ADDR_W-1:0]       buf_addr,
  output logic                    buf_rd,
  input  logic [7:0]              buf_rdata,
  output logic                    buf_we,
  output logic [7:0]              buf_wdata
);
  localparam int BIAS = SECT_BYTES + 7;

  seq_st_t st;
  logic [PAR_BYTES*8-1:0]         par_q;
  logic [IDX_W-1:0]               idx_q;
  logic [1:0]                     k_q;
  logic [2:0]                     nerr_q;
  logic [NERR-1:0][RAW_W-1:0]     raw_q;
  logic [NERR-1:0][MASK_W-1:0]    msk_q;
  logic [MASK_W-1:0]              xv_q;

  logic                           erased;
  logic [NWORDS-1:0][WORD_W-1:0]  words;
  logic [ADDR_W-1:0]              pick_off;
  logic [MASK_W-1:0]              pick_xor;
  logic                           pick_hit;
  logic                           poll_busy, poll_tick, poll_expired;
  logic                           last_err;

  ecc4_parity_unpack #(.NB(PAR_BYTES), .NW(NWORDS), .WW(WORD_W)) u_unpack (
    .par(par_q), .erased(erased), .words(words));

  ecc4_err_pick #(.SECT(SECT_BYTES), .BIAS(BIAS), .AW(ADDR_W)) u_pick (
    .raw(raw_q), .msk(msk_q), .sel(k_q),
    .offset(pick_off), .xorv(pick_xor), .hit(pick_hit));

  assign poll_busy = |eng_stat[11:10];
  assign poll_tick = (st == S_POLL) && poll_busy;

  ecc4_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .clr(st == S_CALC), .tick(poll_tick),
    .expired(poll_expired));

  assign busy           = (st != S_IDLE);
  assign eng_load       = (st == S_LOAD);
  assign eng_load_val   = words[idx_q];
  assign eng_calc_start = (st == S_CALC);
  assign last_err       = (k_q == 2'(nerr_q - 3'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      par_q         <= '0;
      idx_q         <= '0;
      k_q           <= '0;
      nerr_q        <= '0;
      raw_q         <= '0;
      msk_q         <= '0;
      xv_q          <= '0;
      done          <= 1'b0;
      uncorrectable <= 1'b0;
      err_count     <= '0;
      buf_addr      <= '0;
      buf_rd        <= 1'b0;
      buf_we        <= 1'b0;
      buf_wdata     <= '0;
    end else begin
      done   <= 1'b0;
      buf_rd <= 1'b0;
      buf_we <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          par_q         <= parity;
          uncorrectable <= 1'b0;
          err_count     <= '0;
          nerr_q        <= '0;
          st            <= S_CHK;
        end
        S_CHK: begin
          idx_q <= IDX_W'(NWORDS - 1);
          st    <= erased ? S_FIN : S_LOAD;
        end
        S_LOAD: begin
          if (idx_q == '0) st <= S_GAP;
          else             idx_q <= idx_q - 1'b1;
        end
        S_GAP:  st <= S_SYN;
        S_SYN:  st <= (eng_synd == '0) ? S_FIN : S_CALC;
        S_CALC: st <= S_POLL;
        S_POLL: begin
          if (!poll_busy) begin
            case (eng_stat[9:8])
              2'd0: st <= S_FIN;
              2'd1: begin uncorrectable <= 1'b1; st <= S_FIN; end
              default: begin
                nerr_q    <= {1'b0, eng_stat[17:16]} + 3'd1;
                err_count <= {1'b0, eng_stat[17:16]} + 3'd1;
                raw_q[0]  <= eng_addr_a[RAW_W-1:0];
                raw_q[1]  <= eng_addr_a[16 +: RAW_W];
                raw_q[2]  <= eng_addr_b[RAW_W-1:0];
                raw_q[3]  <= eng_addr_b[16 +: RAW_W];
                msk_q[0]  <= eng_val_a[MASK_W-1:0];
                msk_q[1]  <= eng_val_a[16 +: MASK_W];
                msk_q[2]  <= eng_val_b[MASK_W-1:0];
                msk_q[3]  <= eng_val_b[16 +: MASK_W];
                k_q       <= '0;
                st        <= S_PICK;
              end
            endcase
          end else if (poll_expired) begin
            uncorrectable <= 1'b1;
            st            <= S_FIN;
          end
        end
        S_PICK: begin
          if (pick_hit) begin
            buf_rd   <= 1'b1;
            buf_addr <= pick_off;
            xv_q     <= pick_xor;
            st       <= S_RD;
          end else if (last_err) begin
            st <= S_FIN;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        S_RD: st <= S_WR;
        S_WR: begin
          buf_we    <= 1'b1;
          buf_wdata <= buf_rdata ^ xv_q;
          if (last_err) st <= S_FIN;
          else begin
            k_q <= k_q + 1'b1;
            st  <= S_PICK;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc4_seq_chk.sv
module ecc4_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       uncorrectable,
  input logic [2:0] err_count,
  input logic       eng_load,
  input logic       eng_calc_start,
  input logic       buf_rd,
  input logic       buf_we
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_CALC_PULSE: assert property (@(posedge clk) disable iff (rst)
    eng_calc_start |=> !eng_calc_start); // R5
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    eng_load |-> busy); // R3
  AST_WE_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(buf_rd, 2)); // R9
  AST_UNC_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (done && uncorrectable) |-> (err_count == 3'd0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!buf_rd && !eng_calc_start && !eng_load)); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($stable(err_count) && $stable(uncorrectable))); // R12
endmodule

bind ecc4_fix_seq ecc4_seq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .uncorrectable(uncorrectable), .err_count(err_count),
  .eng_load(eng_load), .eng_calc_start(eng_calc_start),
  .buf_rd(buf_rd), .buf_we(buf_we));

// File: tb/tb_ecc4_fix_seq.sv
module tb_ecc4_fix_seq;
  localparam int LIMIT = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [79:0] parity = '0;
  logic        busy, done, unc, eng_load, eng_calc_start, buf_rd, buf_we;
  logic [2:0]  err_count;
  logic [9:0]  eng_load_val;
  logic [39:0] eng_synd;
  logic [17:0] eng_stat;
  logic [31:0] addr_a, addr_b, val_a, val_b;
  logic [8:0]  buf_addr;
  logic [7:0]  buf_rdata, buf_wdata;

  always #4 clk = ~clk;

  ecc4_fix_seq #(.POLL_LIMIT(LIMIT)) dut (
    .clk(clk), .rst(rst), .start(start), .parity(parity), .busy(busy),
    .done(done), .uncorrectable(unc), .err_count(err_count),
    .eng_load(eng_load), .eng_load_val(eng_load_val), .eng_synd(eng_synd),
    .eng_calc_start(eng_calc_start), .eng_stat(eng_stat),
    .eng_addr_a(addr_a), .eng_addr_b(addr_b), .eng_val_a(val_a), .eng_val_b(val_b),
    .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
    .buf_we(buf_we), .buf_wdata(buf_wdata));

  // sector buffer with registered read
  logic [7:0] mem [512];
  logic [7:0] ref_mem [512];
  logic       mem_init = 1'b0;
  always @(posedge clk) begin
    if (mem_init) begin
      for (int i = 0; i < 512; i++) mem[i] <= ref_mem[i];
    end else begin
      if (buf_rd) buf_rdata <= mem[buf_addr];
      if (buf_we) mem[buf_addr] <= buf_wdata;
    end
  end

  // scripted engine
  logic [39:0] cfg_synd;
  logic [1:0]  cfg_code, cfg_cnt;
  logic        cfg_stuck;
  logic [15:0] cfg_delay;
  logic [9:0]  cfg_raw [4];
  logic [7:0]  cfg_val [4];
  logic [9:0]  ld [16];
  int          ldn, calcn, gap;
  logic        log_clr = 1'b0;
  logic [15:0] bcnt;

  always @(posedge clk) begin
    if (log_clr) begin
      ldn <= 0; calcn <= 0; gap <= 3; bcnt <= '0;
    end else begin
      if (eng_load) begin
        if (ldn < 16) ld[ldn] <= eng_load_val;
        ldn <= ldn + 1;
        gap <= 0;
      end else if (gap < 3) gap <= gap + 1;
      if (eng_calc_start) begin
        calcn <= calcn + 1;
        bcnt  <= cfg_delay;
      end else if (bcnt != 0 && !cfg_stuck) bcnt <= bcnt - 1'b1;
    end
  end
  assign eng_synd = (gap >= 1) ? cfg_synd : 40'h5_A5A5_A5A5A;
  assign eng_stat = {cfg_cnt, 4'b0, (bcnt != 0) ? 2'b11 : 2'b00, cfg_code, 8'h00};
  assign addr_a = {6'b0, cfg_raw[1], 6'b0, cfg_raw[0]};
  assign addr_b = {6'b0, cfg_raw[3], 6'b0, cfg_raw[2]};
  assign val_a  = {8'b0, cfg_val[1], 8'b0, cfg_val[0]};
  assign val_b  = {8'b0, cfg_val[3], 8'b0, cfg_val[2]};

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] word_of(input logic [79:0] p, input int i);
    return p[i*10 +: 10];
  endfunction

  task automatic run_case(input logic [79:0] p, input bit poke_mid);
    bit erased, synd_zero, timed;
    int exp_cnt, wait_cyc, bad;
    bit exp_unc;
    // fresh sector content
    for (int i = 0; i < 512; i++) ref_mem[i] = 8'($urandom);
    @(negedge clk); mem_init = 1'b1; log_clr = 1'b1;
    @(negedge clk); mem_init = 1'b0; log_clr = 1'b0;
    erased = (p == {80{1'b1}});
    synd_zero = (cfg_synd == '0);
    exp_cnt = 0; exp_unc = 1'b0;
    if (!erased && !synd_zero) begin
      if (cfg_stuck) exp_unc = 1'b1;
      else if (cfg_code == 2'd1) exp_unc = 1'b1;
      else if (cfg_code >= 2'd2) begin
        exp_cnt = int'(cfg_cnt) + 1;
        for (int k = 0; k < exp_cnt; k++) begin
          int off;
          off = 519 - int'(cfg_raw[k]);
          if (off >= 0 && off < 512) ref_mem[off] = ref_mem[off] ^ cfg_val[k];
        end
      end
    end
    parity = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_mid) begin
      repeat (3) @(negedge clk);
      parity = {80{1'b1}}; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait_cyc = 0; timed = 1'b0;
    while (!done && !timed) begin
      @(negedge clk);
      wait_cyc++;
      if (wait_cyc > 2000) timed = 1'b1;
    end
    chk(!timed, "R12 done reached", wait_cyc, 0);
    chk(unc == exp_unc, exp_unc ? (cfg_stuck ? "R10 timeout unc" : "R6 unc flag") : "R6 unc flag",
        unc, exp_unc);
    chk(err_count == 3'(exp_cnt), "R7 err_count", err_count, exp_cnt);
    if (erased) chk(ldn == 0, "R1 no loads on erased", ldn, 0);
    else begin
      chk(ldn == 8, "R3 load count", ldn, 8);
      bad = 0;
      for (int j = 0; j < 8; j++) if (ld[j] != word_of(p, 7 - j)) bad++;
      chk(bad == 0, "R2 R3 load words and order", bad, 0);
    end
    chk(calcn == ((!erased && !synd_zero) ? 1 : 0), "R4 R5 calc start count", calcn,
        (!erased && !synd_zero) ? 1 : 0);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != ref_mem[i]) bad++;
    chk(bad == 0, "R8 R9 sector contents", bad, 0);
    @(negedge clk);
    chk(!done && !busy, "R11 R12 single pulse, no restart", {done, busy}, 0);
    chk(unc == exp_unc && err_count == 3'(exp_cnt), "R12 results held", err_count, exp_cnt);
  endtask

  task automatic set_eng(input logic [39:0] s, input logic [1:0] code, input logic [1:0] cnt,
                         input logic [15:0] dly, input bit stuck);
    cfg_synd = s; cfg_code = code; cfg_cnt = cnt; cfg_delay = dly; cfg_stuck = stuck;
  endtask

  initial begin
    int guard = 0;
    while (guard < 190000) begin @(posedge clk); guard++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [79:0] p;
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) begin cfg_raw[k] = 10'd100; cfg_val[k] = 8'h01; end
    set_eng(40'h1, 2'd3, 2'd0, 16'd3, 1'b0);
    repeat (4) @(negedge clk);
    chk(!busy && !done && !unc && err_count == 0 && !buf_we && !eng_load,
        "R12 reset state", {busy, done, unc, err_count}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 erased sector
    run_case({80{1'b1}}, 1'b0);
    // R4 zero syndrome, sampled after idle cycle
    set_eng(40'h0, 2'd3, 2'd3, 16'd2, 1'b0);
    run_case(80'h0123_4567_89AB_CDEF_0F1E, 1'b0);
    // R6 code 0 and code 1
    set_eng(40'h3, 2'd0, 2'd3, 16'd5, 1'b0);
    run_case(80'hFFFF_FFFF_FFFF_FFFF_FFFE, 1'b0);
    set_eng(40'h3, 2'd1, 2'd3, 16'd5, 1'b0);
    run_case(80'h0000_0000_0000_0000_0000, 1'b0);
    // R10 poll timeout
    set_eng(40'h7, 2'd3, 2'd3, 16'hFFFF, 1'b1);
    run_case(80'h1357_9BDF_2468_ACE0_1122, 1'b0);
    // R9 offset window edges: raw 8 -> 511, 519 -> 0, 7 and 520 dropped
    cfg_raw[0] = 10'd8;   cfg_val[0] = 8'hA5;
    cfg_raw[1] = 10'd7;   cfg_val[1] = 8'h3C;
    cfg_raw[2] = 10'd519; cfg_val[2] = 8'h81;
    cfg_raw[3] = 10'd520; cfg_val[3] = 8'hFF;
    set_eng(40'h9, 2'd3, 2'd3, 16'd4, 1'b0);
    run_case(80'hDEAD_BEEF_CAFE_F00D_5A5A, 1'b0);
    // R9 repeated offset accumulates, code 2, three errors, R11 mid-run start
    cfg_raw[0] = 10'd300; cfg_val[0] = 8'h0F;
    cfg_raw[1] = 10'd300; cfg_val[1] = 8'hF1;
    cfg_raw[2] = 10'd10;  cfg_val[2] = 8'h42;
    set_eng(40'h1_0000_0000, 2'd2, 2'd2, 16'd1, 1'b0);
    run_case(80'h0F0F_F0F0_3333_CCCC_9999, 1'b1);

    // random runs
    for (int r = 0; r < 40; r++) begin
      p = {16'($urandom), $urandom, $urandom};
      for (int k = 0; k < 4; k++) begin
        cfg_raw[k] = ($urandom % 5 == 0) ? 10'($urandom) : 10'(8 + $urandom % 512);
        cfg_val[k] = 8'($urandom | 1);
      end
      set_eng(($urandom % 5 == 0) ? 40'h0 : {8'($urandom), $urandom | 1},
              ($urandom % 6 == 0) ? 2'($urandom % 2) : 2'(2 + $urandom % 2),
              2'($urandom), 16'($urandom % 12), 1'b0);
      run_case(p, (r % 7) == 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule